// File: doc/BRIEF.md
# Nibble-Table Dual-Read Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. It contains no logic multiplier. Both operands may change on every operation. Each operand is split into a low and a high 4-bit nibble, giving four nibble products. The block reads these from one small product table that has two read ports. The table is built inside the block by an elaboration-time loop, so no external memory image is needed.

The two ports are used over two clock cycles:

- In the cycle that the block accepts an operation, the two ports read the "diagonal" nibble pairs, low by low and high by high.
- In the next cycle, they read the two "cross" pairs.

A shift-and-add stage then combines the four partial products. The result appears with a one-cycle valid pulse. A new operation can be accepted in the same cycle that the previous result is presented, so the block sustains one product every three cycles.

Top module: `nibble_rom_mult`

## Requirements
- R1: While reset is held and right after it is released, `outValid` is 0 and `product` is 0.
- R2: For every unsigned pair (a, b) with 0 <= a, b <= 255, the presented `product` equals a*b as a 16-bit unsigned value.
- R3: The product table has 256 entries of 8 bits. The entry at address {x, y}, with x in address bits 7:4 and y in bits 3:0, holds x*y. Each port returns the entry one clock after its address is presented.
- R4: In the cycle after acceptance, the two table ports hold aLo*bLo and aHi*bHi. In the following cycle, they hold aLo*bHi and aHi*bLo. Here Lo means bits 3:0 and Hi means bits 7:4.
- R5: If `inValid` is sampled high at clock edge k while the block is idle, `outValid` is high for exactly one cycle, after edge k+2, and `product` is valid in that cycle.
- R6: `inValid` sampled high during the two cycles after an acceptance is ignored. It produces no extra `outValid` pulse, and its operands do not alter the result in flight.
- R7: `inValid` may be high in the cycle where `outValid` is high, and that operation is accepted. A stream of such operations yields one correct result every three cycles.
- R8: `product` keeps its value until the next `outValid` pulse.
- R9: Operands are captured when the operation is accepted. Later changes on `opA` and `opB` do not affect that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Start request; accepted when the block is idle |
| opA | input | 8 | Unsigned multiplicand |
| opB | input | 8 | Unsigned multiplier |
| outValid | output | 1 | One-cycle pulse marking a new result |
| product | output | 16 | Unsigned result, held between pulses |

## Verification
Embedded properties check the following on every cycle:

- Each table read port returns the nibble product of the address it saw one clock earlier.
- The two ports carry the diagonal pairs and then the cross pairs of the captured operands.
- Every result pulse carries the product of the captured operands.
- The control sequence is idle, cross phase, sum, with no re-acceptance in between.
- The result holds between pulses.

Only the bench's scenarios can show the following:

- The full 256x256 operand space, streamed back to back.
- The exact latency, seen at the ports.
- That starts arriving mid-operation, and operand changes after acceptance, leave the output untouched.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadOps;   // accept operands, present diagonal addresses
    logic capDiag;   // table outputs hold diagonal partial products
    logic capCross;  // table outputs hold cross partial products
    logic busy;      // an operation is in flight
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CROSS = 2'd1,
    ST_SUM   = 2'd2
  } seqState_t;

endpackage

// File: rtl/nrm_prod_rom.sv
module nrm_prod_rom #(
  parameter int NIB_W     = 4,
  parameter int NUM_PORTS = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_PORTS-1:0][2*NIB_W-1:0]     rdAddr,
  output logic [NUM_PORTS-1:0][2*NIB_W-1:0]     rdData
);

  localparam int ADDR_W  = 2 * NIB_W;
  localparam int ENTRY_W = 2 * NIB_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NIB_MAX = (1 << NIB_W) - 1;

  logic [ENTRY_W-1:0] prodTable [DEPTH];

  // Table contents: upper address nibble times lower address nibble
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int HI_NIB = g >> NIB_W;
    localparam int LO_NIB = g & NIB_MAX;
    localparam int PROD   = HI_NIB * LO_NIB;
    assign prodTable[g] = PROD[ENTRY_W-1:0];
  end

  // Independent synchronous read ports
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      rdData[p] <= prodTable[rdAddr[p]];
    end

    // R3
    rd_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (rdData[p] == ENTRY_W'($past(rdAddr[p][ADDR_W-1:NIB_W]) *
                                      $past(rdAddr[p][NIB_W-1:0]))))
      else $error("table port %0d returned wrong nibble product", p);
  end

endmodule

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (inValid) stateNext = ST_CROSS;
      ST_CROSS: stateNext = ST_SUM;
      ST_SUM:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.loadOps  = (state == ST_IDLE) && inValid;
    strobes.capDiag  = (state == ST_CROSS);
    strobes.capCross = (state == ST_SUM);
    strobes.busy     = (state != ST_IDLE);
  end

  // R6
  no_reaccept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadOps |=> (!strobes.loadOps && strobes.capDiag))
    else $error("start re-accepted during operation");

  // R5
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capDiag |=> (strobes.capCross && !strobes.loadOps))
    else $error("cross phase not followed by sum");

  // R5
  sum_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capCross |=> !strobes.busy)
    else $error("sequencer did not return to idle");

endmodule

// File: rtl/nrm_datapath.sv
module nrm_datapath
  import nrm_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  output logic                outValid,
  output logic [2*OP_W-1:0]   product
);

  localparam int NIB_W   = OP_W / 2;
  localparam int ADDR_W  = 2 * NIB_W;
  localparam int ENTRY_W = 2 * NIB_W;
  localparam int RES_W   = 2 * OP_W;

  logic [OP_W-1:0]              aReg, bReg;
  logic [1:0][ADDR_W-1:0]       tblAddr;
  logic [1:0][ENTRY_W-1:0]      tblData;
  logic [RES_W-1:0]             diagSum;
  logic [ENTRY_W:0]             crossSum;

  // Operand capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else if (strobes.loadOps) begin
      aReg <= opA;
      bReg <= opB;
    end
  end

  // Port scheduling: diagonal pairs straight from the inputs on acceptance,
  // cross pairs from the captured operands one cycle later
  always_comb begin
    if (strobes.loadOps) begin
      tblAddr[0] = {opA[NIB_W-1:0],    opB[NIB_W-1:0]};
      tblAddr[1] = {opA[OP_W-1:NIB_W], opB[OP_W-1:NIB_W]};
    end else begin
      tblAddr[0] = {aReg[NIB_W-1:0],    bReg[OP_W-1:NIB_W]};
      tblAddr[1] = {aReg[OP_W-1:NIB_W], bReg[NIB_W-1:0]};
    end
  end

  nrm_prod_rom #(
    .NIB_W     (NIB_W),
    .NUM_PORTS (2)
  ) i_rom (
    .clk    (clk),
    .rstN   (rstN),
    .rdAddr (tblAddr),
    .rdData (tblData)
  );

  // Shifted accumulation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diagSum <= '0;
    end else if (strobes.capDiag) begin
      diagSum <= (RES_W'(tblData[1]) << OP_W) + RES_W'(tblData[0]);
    end
  end

  assign crossSum = {1'b0, tblData[0]} + {1'b0, tblData[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.capCross;
      if (strobes.capCross) begin
        product <= diagSum + (RES_W'(crossSum) << NIB_W);
      end
    end
  end

  // R4
  diag_pp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capDiag |->
      (tblData[0] == ENTRY_W'(aReg[NIB_W-1:0] * bReg[NIB_W-1:0])) &&
      (tblData[1] == ENTRY_W'(aReg[OP_W-1:NIB_W] * bReg[OP_W-1:NIB_W])))
    else $error("diagonal partial products wrong");

  // R4
  cross_pp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capCross |->
      (tblData[0] == ENTRY_W'(aReg[NIB_W-1:0] * bReg[OP_W-1:NIB_W])) &&
      (tblData[1] == ENTRY_W'(aReg[OP_W-1:NIB_W] * bReg[NIB_W-1:0])))
    else $error("cross partial products wrong");

  // R9
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capCross |-> ($stable(aReg) && $stable(bReg)))
    else $error("operands changed mid-operation");

  // R2
  product_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (product == RES_W'(aReg * bReg)))
    else $error("product mismatch");

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid)
    else $error("result pulse longer than one cycle");

  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(product))
    else $error("product changed without a pulse");

endmodule

// File: rtl/nibble_rom_mult.sv
module nibble_rom_mult
  import nrm_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              outValid,
  output logic [2*OP_W-1:0] product
);

  ctrlStrobes_t strobes;

  nrm_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes)
  );

  nrm_datapath #(
    .OP_W (OP_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .product  (product)
  );

endmodule

// File: tb/test_nibble_rom_mult.sv
module test_nibble_rom_mult;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic        outValid;
  logic [15:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nibble_rom_mult i_nibble_rom_mult (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .product  (product)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive an operation at a negedge; the result is visible three negedges later
  task automatic runOne(input logic [7:0] a, input logic [7:0] b, input string req);
    opA = a; opB = b; inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check(outValid == 1'b0, {req, " no early pulse"}, outValid, 0);
    @(negedge clk);
    check(outValid == 1'b0, {req, " no early pulse"}, outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, {req, " pulse"}, outValid, 1);
    check(product == 16'(a * b), req, product, a * b);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && product == 16'd0, "R1 in reset", product, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && product == 16'd0, "R1 after reset", product, 0);
  endtask

  task automatic testDirected();
    runOne(8'd0,   8'd0,   "R2 zero");
    runOne(8'd255, 8'd255, "R2 max");
    runOne(8'd1,   8'd255, "R2 unit");
    runOne(8'h0B,  8'h0D,  "R3 low nibbles only");
    runOne(8'h0F,  8'hF0,  "R4 cross aLo*bHi");
    runOne(8'hF0,  8'h0F,  "R4 cross aHi*bLo");
    runOne(8'hA0,  8'hC0,  "R4 diag high");
  endtask

  task automatic testLatency();
    opA = 8'd12; opB = 8'd34; inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R5 not before edge k+2", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R5 pulse after edge k+2", outValid, 1);
    @(negedge clk);
    check(outValid == 1'b0, "R5 single-cycle pulse", outValid, 0);
    check(product == 16'd408, "R8 hold after pulse", product, 408);
  endtask

  task automatic testIgnore();
    opA = 8'd200; opB = 8'd7; inValid = 1'b1;
    @(negedge clk);
    opA = 8'd3; opB = 8'd5;   // held high while busy: must be ignored
    @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R6 first result pulse", outValid, 1);
    check(product == 16'd1400, "R6 result unaffected", product, 1400);
    @(negedge clk);
    check(outValid == 1'b0, "R6 no extra pulse", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R6 no extra pulse late", outValid, 0);
    check(product == 16'd1400, "R6 product unchanged", product, 1400);
  endtask

  task automatic testCapture();
    opA = 8'd99; opB = 8'd77; inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    opA = 8'd1; opB = 8'd2;
    @(negedge clk);
    opA = 8'd250; opB = 8'd250;
    @(negedge clk);
    check(product == 16'd7623, "R9 captured operands", product, 7623);
  endtask

  task automatic testHold();
    int held;
    held = product;
    repeat (6) begin
      @(negedge clk);
      check(outValid == 1'b0 && product == 16'(held), "R8 hold while idle", product, held);
    end
  endtask

  task automatic testBackToBack();
    logic [7:0] av [4] = '{8'd17, 8'd255, 8'd128, 8'd66};
    logic [7:0] bv [4] = '{8'd240, 8'd1, 8'd129, 8'd77};
    opA = av[0]; opB = bv[0]; inValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      repeat (3) @(negedge clk);
      check(outValid == 1'b1 && product == 16'(av[i] * bv[i]), "R7 back-to-back",
            product, av[i] * bv[i]);
      if (i < 3) begin
        opA = av[i+1]; opB = bv[i+1];
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  // Every operand pair, streamed one per three cycles
  task automatic testExhaustive();
    int bad = 0;
    opA = 8'd0; opB = 8'd0; inValid = 1'b1;
    for (int n = 0; n < 65536; n++) begin
      int a = n >> 8;
      int b = n & 255;
      repeat (3) @(negedge clk);
      if (!(outValid == 1'b1 && product == 16'(a * b))) begin
        bad++;
        if (bad <= 10) check(1'b0, "R2 exhaustive", product, a * b);
      end else begin
        checks++;
      end
      if (n < 65535) begin
        opA = 8'((n + 1) >> 8); opB = 8'((n + 1) & 255);
      end else begin
        inValid = 1'b0;
      end
    end
    if (bad > 10) errors += bad - 10;
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testDirected();
    testLatency();
    testIgnore();
    testCapture();
    testHold();
    testBackToBack();
    testExhaustive();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (199800) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule